// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block resolves the operand or jump address for a small one-address processor whose 12-bit instruction word carries a 6-bit function code above a 6-bit execution field. The caller slices the execution field out of the instruction and presents it with the current program counter value, the addressing mode chosen by its opcode decoder, and a flag saying whether a jump is taken. The block returns a 12-bit word with a one-cycle `done` strobe. The word is either an address or an immediate operand, and `isImm` tells the two apart. It also returns the program counter value for the next instruction.

Five modes are supported. Two take no memory access: the page-zero direct address and the zero-extended constant. One adds the execution field to P. Two read a pointer word from memory: one reads from page zero, and the jump variant reads from location P plus the field. For the modes that read memory, the block drives a read request and holds it until the memory answers. While that request is outstanding, it refuses any new request.

Top module: `eaGen`

## Requirements
- R1: Mode code 0 (direct) returns the execution field zero-extended to 12 bits, with `isImm` low. No memory read is made, and `done` rises one cycle after the request is accepted.
- R2: Mode code 1 (indirect) drives `memRd` with `memAddr` equal to the zero-extended execution field. The word returned on `memData` becomes `result`.
- R3: Mode code 2 (relative) returns P plus the zero-extended execution field, taken modulo 4096, with no memory read.
- R4: Mode code 3 (immediate) returns the execution field with its upper six bits zero and sets `isImm`. No memory read is made.
- R5: Mode code 4 (pointer jump) reads the word at (P + field) mod 4096. That word becomes both `result` and `nextPc`, whatever `jumpTaken` says.
- R6: Once raised, `memRd` stays high with `memAddr` unchanged until the first cycle in which `memValid` is sampled high. On the next cycle `memRd` is low and `done` is high for exactly one cycle.
- R7: `reqReady` is high only when no memory read is pending. A request presented while it is low is ignored and leaves the pending result unchanged.
- R8: `nextPc` equals P + 1 (mod 4096) unless `jumpTaken` is set in a non-immediate mode, in which case it equals `result`. In immediate mode, `jumpTaken` has no effect.
- R9: Unused mode codes 5, 6 and 7 behave exactly like direct mode.
- R10: After reset, `reqReady` is high and both `done` and `memRd` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqReady | output | 1 | Block idle, request will be taken |
| mode | input | 3 | Addressing mode code |
| execField | input | FIELD_W | Execution field of the instruction |
| pc | input | WORD_W | Address of the current instruction (P) |
| jumpTaken | input | 1 | Instruction is a jump that is taken |
| memRd | output | 1 | Pointer read request |
| memAddr | output | WORD_W | Pointer address |
| memValid | input | 1 | Read data valid |
| memData | input | WORD_W | Read data |
| done | output | 1 | One-cycle strobe: outputs valid |
| result | output | WORD_W | Effective address or immediate operand |
| isImm | output | 1 | `result` is an immediate operand |
| nextPc | output | WORD_W | Program counter for the next instruction |

## Verification
The bench builds the block with its default widths: a 12-bit word and a 6-bit field. With those widths, a single vector reaches the 4096 wrap of the P-relative sum and the top of the 64-word page. Vectors of each mode drive the program counter near 0xFFF and set the field to 0x3F. This exercises both carries and the all-ones field. Read latencies of zero to three idle cycles, plus a request injected during a pending read, cover the handshake ordering.

// File: rtl/eaPkg.sv
package eaPkg;
  typedef enum logic [2:0] {
    MODE_DIRECT   = 3'd0,
    MODE_INDIRECT = 3'd1,
    MODE_RELATIVE = 3'd2,
    MODE_IMMED    = 3'd3,
    MODE_PTR_JUMP = 3'd4
  } addrMode_e;

  typedef struct packed {
    logic capReq;  // latch request fields and first-stage address
    logic capMem;  // replace address with the word read from memory
  } eaStrobe_t;

  function automatic logic needsFetch(input logic [2:0] m);
    return (m == MODE_INDIRECT) || (m == MODE_PTR_JUMP);
  endfunction
endpackage

// File: rtl/eaCtrl.sv
module eaCtrl
  import eaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  mode,
  input  logic        memValid,
  output eaStrobe_t   strobe,
  output logic        reqReady,
  output logic        memRd,
  output logic        done
);
  typedef enum logic {ST_IDLE, ST_FETCH} state_e;
  state_e state, stateNxt;
  logic   doneNxt;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    doneNxt  = 1'b0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.capReq = 1'b1;
        if (needsFetch(mode)) stateNxt = ST_FETCH;
        else                  doneNxt  = 1'b1;
      end
      ST_FETCH: if (memValid) begin
        strobe.capMem = 1'b1;
        stateNxt      = ST_IDLE;
        doneNxt       = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign memRd    = (state == ST_FETCH);

  // R6
  hold_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd && !memValid |=> memRd);
  // R6
  done_after_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd && memValid |=> done && !memRd);
  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> !reqReady);
  // R1
  no_fetch_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && reqValid && (mode == MODE_DIRECT) |=> done && !memRd);
endmodule

// File: rtl/eaDatapath.sv
module eaDatapath
  import eaPkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  eaStrobe_t          strobe,
  input  logic [2:0]         mode,
  input  logic [FIELD_W-1:0] execField,
  input  logic [WORD_W-1:0]  pc,
  input  logic               jumpTaken,
  input  logic [WORD_W-1:0]  memData,
  output logic [WORD_W-1:0]  memAddr,
  output logic [WORD_W-1:0]  result,
  output logic               isImm,
  output logic [WORD_W-1:0]  nextPc
);
  localparam int PAD_W = WORD_W - FIELD_W;
  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  logic [WORD_W-1:0] fieldExt, relSum, addrSel;
  logic [WORD_W-1:0] eaReg, pcInc;
  logic              immReg, jmpReg, modeImm, jumpSel;

  assign fieldExt = {{PAD_W{1'b0}}, execField};
  assign relSum   = pc + fieldExt;  // wraps modulo 2^WORD_W

  always_comb begin
    case (mode)
      MODE_RELATIVE, MODE_PTR_JUMP: addrSel = relSum;
      default:                      addrSel = fieldExt;
    endcase
  end

  assign modeImm = (mode == MODE_IMMED);
  assign jumpSel = (jumpTaken && !modeImm) || (mode == MODE_PTR_JUMP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaReg  <= '0;
      pcInc  <= '0;
      immReg <= 1'b0;
      jmpReg <= 1'b0;
    end else if (strobe.capReq) begin
      eaReg  <= addrSel;
      pcInc  <= pc + ONE;
      immReg <= modeImm;
      jmpReg <= jumpSel;
    end else if (strobe.capMem) begin
      eaReg  <= memData;
    end
  end

  assign memAddr = eaReg;
  assign result  = eaReg;
  assign isImm   = immReg;
  assign nextPc  = jmpReg ? eaReg : pcInc;

  // R4
  imm_zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    isImm |-> (result[WORD_W-1:FIELD_W] == '0));
endmodule

// File: rtl/eaGen.sv
module eaGen
  import eaPkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [2:0]         mode,
  input  logic [FIELD_W-1:0] execField,
  input  logic [WORD_W-1:0]  pc,
  input  logic               jumpTaken,
  output logic               memRd,
  output logic [WORD_W-1:0]  memAddr,
  input  logic               memValid,
  input  logic [WORD_W-1:0]  memData,
  output logic               done,
  output logic [WORD_W-1:0]  result,
  output logic               isImm,
  output logic [WORD_W-1:0]  nextPc
);
  eaStrobe_t strobe;

  eaCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode),
    .memValid(memValid), .strobe(strobe), .reqReady(reqReady),
    .memRd(memRd), .done(done)
  );

  eaDatapath #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode),
    .execField(execField), .pc(pc), .jumpTaken(jumpTaken),
    .memData(memData), .memAddr(memAddr), .result(result),
    .isImm(isImm), .nextPc(nextPc)
  );

  // R6
  ptr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd && !memValid |=> $stable(memAddr));
endmodule

// File: tb/test_eaGen.sv
module test_eaGen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, jumpTaken = 1'b0, memValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [5:0]  execField = '0;
  logic [11:0] pc = '0, memData = '0;
  logic        reqReady, memRd, done, isImm;
  logic [11:0] memAddr, result, nextPc;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eaGen i_eaGen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .mode(mode), .execField(execField), .pc(pc), .jumpTaken(jumpTaken),
    .memRd(memRd), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .done(done), .result(result), .isImm(isImm), .nextPc(nextPc)
  );

  // vector: {mode[3], jump[1], field[6], pc[12], latency[4]}
  localparam logic [25:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 6'h2A, 12'h100, 4'd0},  // R1
    {3'd0, 1'b1, 6'h3F, 12'h7FF, 4'd0},  // R1 R8
    {3'd1, 1'b0, 6'h05, 12'h200, 4'd0},  // R2
    {3'd1, 1'b1, 6'h3F, 12'hABC, 4'd3},  // R2 R8
    {3'd2, 1'b0, 6'h10, 12'h123, 4'd0},  // R3
    {3'd2, 1'b1, 6'h3F, 12'hFFF, 4'd0},  // R3 wrap
    {3'd3, 1'b1, 6'h3F, 12'h050, 4'd0},  // R4 R8
    {3'd3, 1'b0, 6'h00, 12'hFFF, 4'd0},  // R4 R8 pc wrap
    {3'd4, 1'b0, 6'h08, 12'hFF0, 4'd2},  // R5
    {3'd4, 1'b0, 6'h3F, 12'hFFE, 4'd1},  // R5 wrap
    {3'd5, 1'b0, 6'h11, 12'h400, 4'd0},  // R9
    {3'd7, 1'b1, 6'h22, 12'h401, 4'd0}   // R9
  };

  function automatic logic [11:0] memWord(input logic [11:0] a);
    return a * 12'd37 + 12'h155;
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issues one request; busy=1 injects an extra request while a read is pending.
  task automatic runReq(input logic [2:0] m, input logic j, input logic [5:0] f,
                        input logic [11:0] p, input int lat, input bit busy, input string req);
    logic        fetch, imm, jmp;
    logic [11:0] addr1, expRes, expNext;
    fetch = (m == 3'd1) || (m == 3'd4);
    imm   = (m == 3'd3);
    addr1 = (m == 3'd2 || m == 3'd4) ? p + {6'b0, f} : {6'b0, f};
    expRes = fetch ? memWord(addr1) : addr1;
    jmp    = (m == 3'd4) || (j && !imm);
    expNext = jmp ? expRes : p + 12'd1;
    @(negedge clk);
    check({req, " ready"}, {11'b0, reqReady}, 12'd1);
    reqValid = 1'b1; mode = m; jumpTaken = j; execField = f; pc = p;
    @(negedge clk);
    reqValid = 1'b0;
    if (fetch) begin
      check({req, " memRd raised"}, {11'b0, memRd}, 12'd1);
      check({req, " pointer"}, memAddr, addr1);
      for (int k = 0; k < lat; k++) begin
        if (busy) begin
          reqValid = 1'b1; mode = 3'd0; execField = 6'h01; pc = 12'h000;
        end
        @(negedge clk);
        check({req, " R6 memRd held"}, {11'b0, memRd}, 12'd1);
        check({req, " R6 pointer stable"}, memAddr, addr1);
        if (busy) check("R7 not ready while busy", {11'b0, reqReady}, 12'd0);
      end
      reqValid = 1'b0;
      memValid = 1'b1; memData = memWord(addr1);
      @(negedge clk);
      memValid = 1'b0; memData = 12'h000;
      check({req, " R6 memRd dropped"}, {11'b0, memRd}, 12'd0);
    end else begin
      check({req, " no read"}, {11'b0, memRd}, 12'd0);
    end
    check({req, " done"}, {11'b0, done}, 12'd1);
    check({req, " result"}, result, expRes);
    check({req, " isImm"}, {11'b0, isImm}, {11'b0, imm});
    check({req, " R8 nextPc"}, nextPc, expNext);
    @(negedge clk);
    check({req, " R6 done single"}, {11'b0, done}, 12'd0);
    if (busy) check("R7 busy request ignored", result, expRes);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R10 ready", {11'b0, reqReady}, 12'd1);
    check("R10 done", {11'b0, done}, 12'd0);
    check("R10 memRd", {11'b0, memRd}, 12'd0);
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      case (VEC[i][25:23])
        3'd0: tag = "R1 direct";
        3'd1: tag = "R2 indirect";
        3'd2: tag = "R3 relative";
        3'd3: tag = "R4 immediate";
        3'd4: tag = "R5 ptr jump";
        default: tag = "R9 unused mode";
      endcase
      runReq(VEC[i][25:23], VEC[i][22], VEC[i][21:16], VEC[i][15:4],
             int'(VEC[i][3:0]), 1'b0, tag);
    end
    // R7: request injected during a pending read is refused
    runReq(3'd1, 1'b0, 6'h3F, 12'h000, 3, 1'b1, "R7 busy");
    // R5: pointer jump ignores jumpTaken low, latency 0
    runReq(3'd4, 1'b0, 6'h01, 12'hFFF, 0, 1'b0, "R5 ptr jump wrap to 0");
    // back-to-back immediate then direct
    runReq(3'd3, 1'b0, 6'h2B, 12'h0FF, 0, 1'b0, "R4 back to back");
    runReq(3'd6, 1'b1, 6'h3F, 12'h0FF, 0, 1'b0, "R9 mode 6");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule